// File: doc/BRIEF.md
# Legacy FM Port Write-Trap Unit

This unit sits on a simple byte-wide I/O slave bus and watches the four-byte legacy FM synthesizer window at 0x388..0x38B. No synthesizer is present. Host writes into that window are captured into three small registers, and a data-port write can raise a non-maskable or system-management interrupt. Handler software then reads the captured bank, index and data back and emulates the synthesizer in firmware.

The captured values appear in a second four-byte window whose base is held in a register set through a side port. A read of that window also serves as the interrupt acknowledge. A control byte enables the trap and chooses which interrupt line is used. Reads of the legacy window always return zero.

Top module: `fm_write_trap`

## Requirements
- R1: The legacy window decodes addresses 0x388 through 0x38B only while `fm_en_i` is high. `io_hit_o` is high in a cycle with a read or write strobe to a decoded address; 0x387 and 0x38C never decode as legacy.
- R2: A legacy write to an even offset sets capture byte 0 to the bank code (0x01 when address bit 1 is 0, 0x02 when it is 1) and capture byte 1 to the written byte, and it raises no interrupt.
- R3: A legacy write to an odd offset stores the written byte in capture byte 2 and leaves capture bytes 0 and 1 unchanged.
- R4: When control bit 0 is 1, a legacy odd-offset write raises `smi_o` (control bit 2 = 1) or `nmi_o` (control bit 2 = 0) from the next cycle on. When control bit 0 is 0, it raises neither line.
- R5: When control bit 0 is 1, a read of the capture window drops the line selected by control bit 2 from the next cycle on. When control bit 0 is 0, the read leaves both lines unchanged.
- R6: When a raise and a drop of the same line happen in the same cycle, the line is high afterwards.
- R7: A control write keeps only the low 4 bits. `ctrl_o` shows the stored byte, with bits 7:4 reading 0.
- R8: A read of the legacy window returns 0x00 on `io_rdata_o`, unless the capture window also decodes that address.
- R9: The capture window base has bits 1:0 forced to 0. The window decodes only while `io_en_i` is high and the forced base is nonzero. Offsets 0, 1 and 2 read capture bytes 0, 1 and 2, and offset 3 reads 0x00. When no capture read is decoded, `io_rdata_o` is 0x00.
- R10: Writes into the capture window change no capture byte and neither interrupt line.
- R11: After reset, all capture bytes, the control byte, the capture base and both interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fm_en_i | input | 1 | Enables decode of the legacy FM window |
| io_en_i | input | 1 | Global I/O enable for the capture window |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data |
| base_we_i | input | 1 | Capture base write strobe |
| base_wdata_i | input | 16 | Capture base write data |
| io_addr_i | input | 16 | I/O bus address |
| io_rd_i | input | 1 | I/O read strobe |
| io_wr_i | input | 1 | I/O write strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data (combinational) |
| io_hit_o | output | 1 | Access decoded by either window |
| ctrl_o | output | 8 | Stored control byte |
| nmi_o | output | 1 | Non-maskable interrupt level |
| smi_o | output | 1 | System-management interrupt level |

## Verification
The hardest case to reach is a raise and an acknowledge of the same line in one cycle. On a single address bus this can only happen when both windows decode the same odd address and the host drives the read and write strobes together. The stimulus moves the capture base onto 0x388 with the trap armed and issues a combined read and write to 0x389. The reference model then expects the line high and the read data taken from the capture bytes.

// File: rtl/fmtrap_pkg.sv
package fmtrap_pkg;
  localparam logic [7:0] BANK_LO = 8'h01;
  localparam logic [7:0] BANK_HI = 8'h02;
  localparam int unsigned CTRL_ARM_BIT = 0;
  localparam int unsigned CTRL_SMI_BIT = 2;
  localparam int unsigned CTRL_KEEP    = 4;
  localparam int unsigned N_CAP        = 3;
  localparam int unsigned N_IRQ        = 2;

  typedef enum logic [1:0] {
    CAP_BANK  = 2'd0,
    CAP_INDEX = 2'd1,
    CAP_DATA  = 2'd2,
    CAP_NONE  = 2'd3
  } cap_sel_e;

  typedef enum logic {
    IRQ_NMI = 1'b0,
    IRQ_SMI = 1'b1
  } irq_sel_e;
endpackage

// File: rtl/fmtrap_decode.sv
module fmtrap_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BYTES = 4,
  parameter logic [ADDR_W-1:0] FM_BASE = 16'h0388
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              fm_en_i,
  input  logic              io_en_i,
  input  logic [ADDR_W-1:0] cap_base_i,
  output logic              leg_hit_o,
  output logic              cap_hit_o
);
  localparam int unsigned OFS_W = $clog2(WIN_BYTES);

  logic base_valid;

  assign base_valid = (cap_base_i[ADDR_W-1:OFS_W] != '0);
  assign leg_hit_o  = fm_en_i && (addr_i[ADDR_W-1:OFS_W] == FM_BASE[ADDR_W-1:OFS_W]);
  assign cap_hit_o  = io_en_i && base_valid &&
                      (addr_i[ADDR_W-1:OFS_W] == cap_base_i[ADDR_W-1:OFS_W]);
endmodule

// File: rtl/fmtrap_capture.sv
module fmtrap_capture
  import fmtrap_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         idx_wr_i,
  input  logic                         dat_wr_i,
  input  logic                         bank_hi_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [1:0]                   rd_ofs_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [N_CAP-1:0][DATA_W-1:0] cap_o
);
  logic [N_CAP-1:0][DATA_W-1:0] cap_q;

  for (genvar g = 0; g < N_CAP; g++) begin : g_cap
    logic             we;
    logic [DATA_W-1:0] nxt;
    always_comb begin
      unique case (g)
        CAP_BANK:  begin we = idx_wr_i; nxt = DATA_W'(bank_hi_i ? BANK_HI : BANK_LO); end
        CAP_INDEX: begin we = idx_wr_i; nxt = wdata_i; end
        default:   begin we = dat_wr_i; nxt = wdata_i; end
      endcase
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cap_q[g] <= '0;
      else if (we)  cap_q[g] <= nxt;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (cap_sel_e'(rd_ofs_i) != CAP_NONE) rdata_o = cap_q[rd_ofs_i];
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/fmtrap_irq.sv
module fmtrap_irq
  import fmtrap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  irq_sel_e         sel_i,
  output logic [N_IRQ-1:0] irq_o
);
  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    logic mine;
    logic q;
    assign mine = (sel_i == irq_sel_e'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            q <= 1'b0;
      else if (set_i && mine) q <= 1'b1;  // set beats clear
      else if (clr_i && mine) q <= 1'b0;
    end
    assign irq_o[g] = q;
  end
endmodule

// File: rtl/fm_write_trap.sv
module fm_write_trap
  import fmtrap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned WIN_BYTES = 4,
  parameter logic [ADDR_W-1:0] FM_BASE = 16'h0388
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fm_en_i,
  input  logic              io_en_i,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  input  logic              base_we_i,
  input  logic [ADDR_W-1:0] base_wdata_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o,
  output logic              io_hit_o,
  output logic [7:0]        ctrl_o,
  output logic              nmi_o,
  output logic              smi_o
);
  localparam int unsigned OFS_W = $clog2(WIN_BYTES);

  logic [7:0]                   ctrl_q;
  logic [ADDR_W-1:0]            base_q;
  logic                         leg_hit, cap_hit;
  logic                         leg_wr, idx_wr, dat_wr, cap_rd;
  logic                         irq_set, irq_clr;
  logic [DATA_W-1:0]            cap_rdata;
  logic [N_CAP-1:0][DATA_W-1:0] cap_q;
  logic [N_IRQ-1:0]             irq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      base_q <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= {{(8-CTRL_KEEP){1'b0}}, ctrl_wdata_i[CTRL_KEEP-1:0]};
      if (base_we_i) base_q <= {base_wdata_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    end
  end

  fmtrap_decode #(
    .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .FM_BASE(FM_BASE)
  ) u_decode (
    .addr_i    (io_addr_i),
    .fm_en_i   (fm_en_i),
    .io_en_i   (io_en_i),
    .cap_base_i(base_q),
    .leg_hit_o (leg_hit),
    .cap_hit_o (cap_hit)
  );

  assign leg_wr  = io_wr_i && leg_hit;
  assign idx_wr  = leg_wr && !io_addr_i[0];
  assign dat_wr  = leg_wr &&  io_addr_i[0];
  assign cap_rd  = io_rd_i && cap_hit;
  assign irq_set = dat_wr && ctrl_q[CTRL_ARM_BIT];
  assign irq_clr = cap_rd && ctrl_q[CTRL_ARM_BIT];

  fmtrap_capture #(.DATA_W(DATA_W)) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_wr_i (idx_wr),
    .dat_wr_i (dat_wr),
    .bank_hi_i(io_addr_i[1]),
    .wdata_i  (io_wdata_i),
    .rd_ofs_i (io_addr_i[1:0]),
    .rdata_o  (cap_rdata),
    .cap_o    (cap_q)
  );

  fmtrap_irq u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (irq_set),
    .clr_i (irq_clr),
    .sel_i (irq_sel_e'(ctrl_q[CTRL_SMI_BIT])),
    .irq_o (irq)
  );

  // legacy reads always return zero; only capture reads drive data
  assign io_rdata_o = cap_rd ? cap_rdata : '0;
  assign io_hit_o   = (io_rd_i || io_wr_i) && (leg_hit || cap_hit);
  assign ctrl_o     = ctrl_q;
  assign nmi_o      = irq[IRQ_NMI];
  assign smi_o      = irq[IRQ_SMI];
endmodule

// File: rtl/fmtrap_checker.sv
module fmtrap_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  fm_en_i,
  input logic                  io_rd_i,
  input logic                  io_wr_i,
  input logic [ADDR_W-1:0]     io_addr_i,
  input logic [DATA_W-1:0]     io_wdata_i,
  input logic [DATA_W-1:0]     io_rdata_o,
  input logic [7:0]            ctrl_o,
  input logic                  nmi_o,
  input logic                  smi_o,
  input logic                  leg_hit,
  input logic                  cap_hit,
  input logic [3*DATA_W-1:0]   cap_q
);
  logic lw_idx, lw_dat;
  assign lw_idx = io_wr_i && leg_hit && !io_addr_i[0];
  assign lw_dat = io_wr_i && leg_hit &&  io_addr_i[0];

  p_fm_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fm_en_i |-> !leg_hit);

  p_bank_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lw_idx |=> (cap_q[DATA_W-1:0] == (($past(io_addr_i[1])) ? 8'h02 : 8'h01))
               && (cap_q[2*DATA_W-1:DATA_W] == $past(io_wdata_i)));

  p_idx_no_irq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lw_idx && !nmi_o && !smi_o) |=> (!nmi_o && !smi_o));

  p_data_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lw_dat |=> $stable(cap_q[2*DATA_W-1:0]) && (cap_q[3*DATA_W-1:2*DATA_W] == $past(io_wdata_i)));

  p_raise_smi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lw_dat && ctrl_o[0] && ctrl_o[2]) |=> smi_o);

  p_raise_nmi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lw_dat && ctrl_o[0] && !ctrl_o[2]) |=> nmi_o);

  p_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && cap_hit && ctrl_o[0] && !lw_dat) |=> (ctrl_o[2] ? !$past(ctrl_o[2]) || !smi_o
                                                                : $past(ctrl_o[2]) || !nmi_o));

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && cap_hit && lw_dat && ctrl_o[0] && !ctrl_o[2]) |=> nmi_o);

  p_ctrl_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[7:4] == 4'h0);

  p_leg_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && leg_hit && !cap_hit) |-> io_rdata_o == '0);

  p_ofs3_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && cap_hit && io_addr_i[1:0] == 2'b11) |-> io_rdata_o == '0);

  p_cap_wr_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && cap_hit && !leg_hit) |=> $stable(cap_q));
endmodule

bind fm_write_trap fmtrap_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fm_en_i   (fm_en_i),
  .io_rd_i   (io_rd_i),
  .io_wr_i   (io_wr_i),
  .io_addr_i (io_addr_i),
  .io_wdata_i(io_wdata_i),
  .io_rdata_o(io_rdata_o),
  .ctrl_o    (ctrl_o),
  .nmi_o     (nmi_o),
  .smi_o     (smi_o),
  .leg_hit   (leg_hit),
  .cap_hit   (cap_hit),
  .cap_q     (cap_q)
);

// File: tb/tb_fm_write_trap.sv
`timescale 1ns/1ps
module tb_fm_write_trap;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fm_en_i = 1'b0, io_en_i = 1'b0;
  logic        ctrl_we_i = 1'b0, base_we_i = 1'b0;
  logic [7:0]  ctrl_wdata_i = '0;
  logic [15:0] base_wdata_i = '0;
  logic [15:0] io_addr_i = '0;
  logic        io_rd_i = 1'b0, io_wr_i = 1'b0;
  logic [7:0]  io_wdata_i = '0;
  logic [7:0]  io_rdata_o, ctrl_o;
  logic        io_hit_o, nmi_o, smi_o;

  int n_chk = 0, n_fail = 0;

  // reference model state
  logic [7:0]  m_cap [3];
  logic [7:0]  m_ctrl;
  logic [15:0] m_base;
  logic        m_nmi, m_smi;

  always #2.5 clk_i = ~clk_i;

  fm_write_trap dut (.*);

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic ctl_st(string tag);
    chk(tag, "nmi_o", int'(nmi_o), int'(m_nmi));
    chk(tag, "smi_o", int'(smi_o), int'(m_smi));
    chk(tag, "ctrl_o", int'(ctrl_o), int'(m_ctrl));
  endtask

  // one bus cycle: drive after negedge, check comb outputs, clock, check regs
  task automatic step(string tag, logic rd, logic wr, logic [15:0] a, logic [7:0] d,
                      logic cwe = 1'b0, logic [7:0] cd = 8'h00,
                      logic bwe = 1'b0, logic [15:0] bd = 16'h0);
    bit leg, capw, set, clr;
    int mb;
    logic [7:0] exp_rd;
    io_rd_i = rd; io_wr_i = wr; io_addr_i = a; io_wdata_i = d;
    ctrl_we_i = cwe; ctrl_wdata_i = cd; base_we_i = bwe; base_wdata_i = bd;
    #1;
    mb   = int'(m_base) & 'hFFFC;
    leg  = fm_en_i && (int'(a) >= 'h388) && (int'(a) <= 'h38B);
    capw = io_en_i && (mb != 0) && (int'(a) >= mb) && (int'(a) < mb + 4);
    exp_rd = (rd && capw) ? ((a[1:0] == 2'd3) ? 8'h00 : m_cap[a[1:0]]) : 8'h00;
    chk(tag, "io_hit_o", int'(io_hit_o), int'((rd || wr) && (leg || capw)));
    chk(tag, "io_rdata_o", int'(io_rdata_o), int'(exp_rd));
    set = wr && leg && a[0] && m_ctrl[0];
    clr = rd && capw && m_ctrl[0];
    if (wr && leg) begin
      if (!a[0]) begin m_cap[0] = a[1] ? 8'h02 : 8'h01; m_cap[1] = d; end
      else m_cap[2] = d;
    end
    if (m_ctrl[2]) begin if (set) m_smi = 1; else if (clr) m_smi = 0; end
    else           begin if (set) m_nmi = 1; else if (clr) m_nmi = 0; end
    if (cwe) m_ctrl = cd & 8'h0F;
    if (bwe) m_base = bd;
    @(posedge clk_i); #1;
    ctl_st(tag);
    @(negedge clk_i);
    io_rd_i = 0; io_wr_i = 0; ctrl_we_i = 0; base_we_i = 0;
  endtask

  task automatic rd_cap(string tag);
    for (int i = 0; i < 4; i++) step(tag, 1, 0, 16'(int'(m_base & 16'hFFFC) + i), 8'h00);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) m_cap[i] = 8'h00;
    m_ctrl = 0; m_base = 0; m_nmi = 0; m_smi = 0;
    #12;
    // R11: reset state
    ctl_st("R11");
    chk("R11", "io_rdata_o", int'(io_rdata_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    fm_en_i = 1; io_en_i = 1;
    step("R11", 0, 0, 16'h0, 8'h0);
    // R9: base low bits forced to zero
    step("R9", 0, 0, 16'h0, 8'h0, 0, 8'h0, 1, 16'h0223);
    rd_cap("R11");
    // R2: index writes, both banks
    step("R2", 0, 1, 16'h0388, 8'h20);
    rd_cap("R2");
    step("R2", 0, 1, 16'h038A, 8'h05);
    rd_cap("R9");
    // R3 / R4: data write unarmed
    step("R3", 0, 1, 16'h0389, 8'h7E);
    rd_cap("R3");
    // R7: upper control bits dropped
    step("R7", 0, 0, 16'h0, 8'h0, 1, 8'hF1);
    // R2: armed index write raises nothing
    step("R2", 0, 1, 16'h0388, 8'h44);
    // R4: NMI
    step("R4", 0, 1, 16'h038B, 8'h99);
    step("R4", 0, 0, 16'h0, 8'h0);
    // R5: capture read acknowledges NMI
    step("R5", 1, 0, 16'h0222, 8'h0);
    // R4: SMI selected
    step("R7", 0, 0, 16'h0, 8'h0, 1, 8'h05);
    step("R4", 0, 1, 16'h0389, 8'h31);
    // R5: disarmed read keeps SMI
    step("R5", 0, 0, 16'h0, 8'h0, 1, 8'h04);
    step("R5", 1, 0, 16'h0220, 8'h0);
    // R4: disarmed data write raises nothing
    step("R4", 0, 1, 16'h0389, 8'h32);
    step("R5", 0, 0, 16'h0, 8'h0, 1, 8'h05);
    step("R5", 1, 0, 16'h0223, 8'h0);
    // R10: capture window writes ignored
    step("R10", 0, 1, 16'h0220, 8'hAA);
    step("R10", 0, 1, 16'h0221, 8'hBB);
    step("R10", 0, 1, 16'h0222, 8'hCC);
    rd_cap("R10");
    // R8: legacy read is zero and hits
    step("R8", 1, 0, 16'h0388, 8'h0);
    step("R8", 1, 0, 16'h038B, 8'h0);
    // R1: window edges and fm gate
    step("R1", 1, 0, 16'h0387, 8'h0);
    step("R1", 0, 1, 16'h038C, 8'h11);
    fm_en_i = 0;
    step("R1", 0, 1, 16'h0389, 8'h12);
    step("R1", 0, 1, 16'h0388, 8'h13);
    rd_cap("R1");
    fm_en_i = 1;
    // R9: io enable gate and zero base
    io_en_i = 0;
    step("R9", 1, 0, 16'h0221, 8'h0);
    io_en_i = 1;
    step("R9", 0, 0, 16'h0, 8'h0, 0, 8'h0, 1, 16'h0003);
    step("R9", 1, 0, 16'h0000, 8'h0);
    step("R9", 1, 0, 16'h0001, 8'h0);
    // R6: overlapping windows, raise and ack together on NMI
    step("R6", 0, 0, 16'h0, 8'h0, 1, 8'h01, 1, 16'h0388);
    step("R6", 1, 1, 16'h0389, 8'h5A);
    step("R6", 0, 0, 16'h0, 8'h0);
    step("R6", 1, 0, 16'h038A, 8'h0);
    // R6: same on SMI
    step("R6", 0, 0, 16'h0, 8'h0, 1, 8'h05);
    step("R6", 1, 1, 16'h038B, 8'hA5);
    step("R6", 1, 0, 16'h0389, 8'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule